// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory Port

This block is the load/store side of a 32-bit processor's data memory. The processor presents one byte address per request, together with an access width of byte, halfword or word. A store also carries write data. A load also carries a flag that chooses whether a narrow result is zero-filled or sign-filled. Behind the port sits a small RAM organised as 32-bit words. Each word is split into four independently writable byte lanes.

Byte order is big-endian: the byte at the lowest address of a word is its most significant byte. Lane 0 (address offset 0) holds bits 31:24 and lane 3 (offset 3) holds bits 7:0. Every access must be naturally aligned for its width. A misaligned request raises a fault flag in the same cycle, and it neither writes memory nor updates the load result. Loads deliver a right-justified 32-bit result one clock after the request. Stores commit on the clock edge that samples the request.

The port has no state machine. Its only sequential state is the RAM, the registered read word and the captured load attributes (offset, width, extension mode).

Top module: `be_mem_port`

## Requirements
- R1: Each address names one 8-bit byte. A word stored at an aligned address A places bits 31:24 at A, bits 23:16 at A+1, bits 15:8 at A+2 and bits 7:0 at A+3. A byte load at A+k returns the corresponding byte.
- R2: A word access (size code 2) with address bits 1:0 not equal to 00 raises `misalign`, and a store of this kind leaves memory unchanged.
- R3: A halfword access (size code 1) with address bit 0 set raises `misalign`, and a store of this kind leaves memory unchanged.
- R4: A byte access (size code 0) never raises `misalign`, whatever the address.
- R5: A halfword load at offset 0 of a stored word returns its upper 16 bits. For example, after 0x12345678 is stored, the result is 0x1234.
- R6: An aligned word load returns the stored 32-bit value unchanged.
- R7: A store writes only the lanes selected by its width and address offset. All other bytes of the word keep their values.
- R8: Narrow loads are zero-extended to 32 bits when `load_unsigned` is 1 and sign-extended from the top bit of the loaded field when it is 0.
- R9: `rdata` changes one clock after an aligned load request. It holds its value across stores, idle cycles and faulting requests, and it is 0 after reset.
- R10: Address bits above the RAM's byte range are ignored, so addresses that differ only in those bits reach the same byte.
- R11: Size code 3 is reserved. Any request with it raises `misalign` and has no effect on memory or on `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores and load capture on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the result path |
| req | input | 1 | Request valid for this cycle |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 32 | Byte address |
| size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| load_unsigned | input | 1 | 1 = zero-extend narrow loads, 0 = sign-extend |
| wdata | input | 32 | Store data, right-justified |
| rdata | output | 32 | Load result, right-justified, valid one clock after the load |
| misalign | output | 1 | Alignment fault for the current request (combinational) |

## Verification
The bench builds the port with `DEPTH_WORDS` = 4, so the whole RAM is 16 bytes. Every byte address can then be swept with every size code and both extension modes, over several stored patterns. A bench-side byte array models memory. Every expected load result and every expected fault is derived arithmetically from that array, the address and the size code. The small depth also makes aliasing cheap to reach: addresses such as 0x40 or 0x100 fold back onto the same 16 bytes.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

endpackage

// File: rtl/be_lane_steer.sv
module be_lane_steer
    import be_mem_pkg::*;
(
    input  logic [1:0]        off,
    input  acc_size_e         size,
    input  logic [WORD_W-1:0] wdata,
    output logic              fault,
    output logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] lane_wdata
);

    always_comb begin
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = off[0];
            SZ_WORD: fault = (off != 2'b00);
            default: fault = 1'b1;
        endcase
    end

    // Lane g carries address offset g (big-endian: lane 0 is bits 31:24).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (off == 2'(g));
                SZ_HALF: hit = (off[1] == (g >= 2));
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end
        assign lane_en[g] = hit & ~fault;
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: lane_wdata = {LANES{wdata[7:0]}};
            SZ_HALF: lane_wdata = {2{wdata[15:0]}};
            default: lane_wdata = wdata;
        endcase
    end

endmodule

// File: rtl/be_word_ram.sv
module be_word_ram
    import be_mem_pkg::*;
#(
    parameter int DEPTH_WORDS = 256,
    parameter int IDX_W       = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [WORD_W-1:0] wword,
    input  logic              rd,
    output logic [WORD_W-1:0] rword
);

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        localparam int HI = WORD_W - 1 - LANE_W * g;
        logic [LANE_W-1:0] mem [DEPTH_WORDS];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) mem[idx] <= wword[HI -: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (rd) q <= mem[idx];
        end

        assign rword[HI -: LANE_W] = q;
    end

endmodule

// File: rtl/be_load_extend.sv
module be_load_extend
    import be_mem_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        off,
    input  acc_size_e         size,
    input  logic              uns,
    output logic [WORD_W-1:0] result
);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        unique case (off)
            2'd0:    byte_v = word[31:24];
            2'd1:    byte_v = word[23:16];
            2'd2:    byte_v = word[15:8];
            default: byte_v = word[7:0];
        endcase
        half_v = off[1] ? word[15:0] : word[31:16];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{24{byte_v[7] & ~uns}}, byte_v};
            SZ_HALF: result = {{16{half_v[15] & ~uns}}, half_v};
            default: result = word;
        endcase
    end

endmodule

// File: rtl/be_mem_port.sv
module be_mem_port
    import be_mem_pkg::*;
#(
    parameter int DEPTH_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        load_unsigned,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        misalign
);

    localparam int IDX_W = $clog2(DEPTH_WORDS);

    acc_size_e         size_e;
    logic              fault;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] lane_wdata;
    logic              wr_go;
    logic              rd_go;
    logic [LANES-1:0]  wr_lanes;
    logic [WORD_W-1:0] rword_q;
    logic [1:0]        off_q;
    acc_size_e         size_q;
    logic              uns_q;
    logic              unused_addr_hi;

    assign size_e         = acc_size_e'(size);
    assign unused_addr_hi = ^addr[31:IDX_W+2];

    be_lane_steer u_steer (
        .off        (addr[1:0]),
        .size       (size_e),
        .wdata      (wdata),
        .fault      (fault),
        .lane_en    (lane_en),
        .lane_wdata (lane_wdata)
    );

    assign misalign = req & fault;
    assign wr_go    = req &  we & ~fault;
    assign rd_go    = req & ~we & ~fault;
    assign wr_lanes = wr_go ? lane_en : '0;

    be_word_ram #(
        .DEPTH_WORDS (DEPTH_WORDS),
        .IDX_W       (IDX_W)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (addr[IDX_W+1:2]),
        .wr_lanes (wr_lanes),
        .wword    (lane_wdata),
        .rd       (rd_go),
        .rword    (rword_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= 2'b00;
            size_q <= SZ_WORD;
            uns_q  <= 1'b0;
        end else if (rd_go) begin
            off_q  <= addr[1:0];
            size_q <= size_e;
            uns_q  <= load_unsigned;
        end
    end

    be_load_extend u_ext (
        .word   (rword_q),
        .off    (off_q),
        .size   (size_q),
        .uns    (uns_q),
        .result (rdata)
    );

    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size_e == SZ_WORD && addr[1:0] != 2'b00) |-> misalign);

    assert_half_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size_e == SZ_HALF && addr[0]) |-> misalign);

    assert_byte_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size_e == SZ_BYTE) |-> !misalign);

    assert_fault_no_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (lane_en == '0));

    assert_half_two_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && size_e == SZ_HALF) |-> ($countones(wr_lanes) == 2));

    assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && size_e == SZ_BYTE) |-> $onehot0(wr_lanes) && wr_lanes != '0);

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_go) |-> $stable(rdata));

    assert_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_go && load_unsigned && size_e == SZ_BYTE) |-> (rdata[31:8] == 24'h0));

    assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_go && !load_unsigned && size_e == SZ_BYTE) |-> (rdata[31:8] == {24{rdata[7]}}));

    assert_rsvd_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size_e == SZ_RSVD) |-> misalign);

endmodule

// File: tb/be_mem_port_tb_top.sv
module be_mem_port_tb_top;

    localparam int DEPTH = 4;
    localparam int NBYTES = DEPTH * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        load_unsigned = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        misalign;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0]  model [NBYTES];
    logic [31:0] exp_rdata = '0;

    always #10 clk = ~clk;

    be_mem_port #(.DEPTH_WORDS(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .we            (we),
        .addr          (addr),
        .size          (size),
        .load_unsigned (load_unsigned),
        .wdata         (wdata),
        .rdata         (rdata),
        .misalign      (misalign)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [1:0] s,
                          input logic u, input logic [31:0] d);
        logic exp_fault;
        int   b;
        string ftag;
        string rtag;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; size = s; load_unsigned = u; wdata = d;
        #2;
        exp_fault = (s == 2'd3) || (s == 2'd2 && a[1:0] != 2'b00) || (s == 2'd1 && a[0]);
        case (s)
            2'd0:    ftag = "R4";
            2'd1:    ftag = "R3";
            2'd2:    ftag = "R2";
            default: ftag = "R11";
        endcase
        check(misalign == exp_fault, ftag, 32'(misalign), 32'(exp_fault));
        b = int'(a) & (NBYTES - 1);
        rtag = "R9";
        if (!exp_fault) begin
            if (w) begin
                case (s)
                    2'd0: model[b] = d[7:0];
                    2'd1: begin model[b] = d[15:8]; model[b+1] = d[7:0]; end
                    default: begin
                        model[b] = d[31:24]; model[b+1] = d[23:16];
                        model[b+2] = d[15:8]; model[b+3] = d[7:0];
                    end
                endcase
            end else begin
                case (s)
                    2'd0: begin
                        exp_rdata = u ? {24'h0, model[b]} : {{24{model[b][7]}}, model[b]};
                        rtag = "R8";
                    end
                    2'd1: begin
                        exp_rdata = u ? {16'h0, model[b], model[b+1]}
                                      : {{16{model[b][7]}}, model[b], model[b+1]};
                        rtag = "R5";
                    end
                    default: begin
                        exp_rdata = {model[b], model[b+1], model[b+2], model[b+3]};
                        rtag = "R6";
                    end
                endcase
            end
        end
        @(negedge clk);
        req = 1'b0;
        check(rdata === exp_rdata, rtag, rdata, exp_rdata);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #2;
        check(rdata === 32'h0 && misalign === 1'b0, "R9", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill, then sweep every address, size code and extension mode.
        for (int r = 0; r < 3; r++) begin
            for (int w = 0; w < DEPTH; w++) begin
                v = (r == 0 && w == 0) ? 32'h12345678 : 32'h9E3779B9 * 32'(r * 4 + w + 7);
                access(1'b1, 32'(w * 4 + r * 256), 2'd2, 1'b0, v);
            end
            for (int a = 0; a < NBYTES; a++)
                for (int s = 0; s < 4; s++)
                    for (int u = 0; u < 2; u++)
                        access(1'b0, 32'(a + (r << 6)), 2'(s), u[0], 32'h0);
        end

        // Big-endian placement and halfword view of a known word.
        access(1'b1, 32'h0, 2'd2, 1'b0, 32'h12345678);
        access(1'b0, 32'h0, 2'd1, 1'b1, 32'h0);
        check(rdata === 32'h00001234, "R5", rdata, 32'h00001234);
        access(1'b0, 32'h0, 2'd0, 1'b1, 32'h0);
        check(rdata === 32'h00000012, "R1", rdata, 32'h00000012);
        access(1'b0, 32'h3, 2'd0, 1'b1, 32'h0);
        check(rdata === 32'h00000078, "R1", rdata, 32'h00000078);
        access(1'b0, 32'h0, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'h12345678, "R6", rdata, 32'h12345678);

        // Extension modes.
        access(1'b1, 32'h4, 2'd2, 1'b0, 32'h80FF7F01);
        access(1'b0, 32'h4, 2'd0, 1'b0, 32'h0);
        check(rdata === 32'hFFFFFF80, "R8", rdata, 32'hFFFFFF80);
        access(1'b0, 32'h4, 2'd0, 1'b1, 32'h0);
        check(rdata === 32'h00000080, "R8", rdata, 32'h00000080);
        access(1'b0, 32'h4, 2'd1, 1'b0, 32'h0);
        check(rdata === 32'hFFFF80FF, "R8", rdata, 32'hFFFF80FF);

        // Lane-limited stores.
        access(1'b1, 32'h4, 2'd2, 1'b0, 32'hAABBCCDD);
        access(1'b1, 32'h6, 2'd0, 1'b0, 32'hFFFFFF11);
        access(1'b0, 32'h4, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'hAABB11DD, "R7", rdata, 32'hAABB11DD);
        access(1'b1, 32'h4, 2'd1, 1'b0, 32'h00005566);
        access(1'b0, 32'h4, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'h556611DD, "R7", rdata, 32'h556611DD);

        // Suppressed stores.
        access(1'b1, 32'h5, 2'd2, 1'b0, 32'h01020304);
        access(1'b1, 32'h7, 2'd1, 1'b0, 32'h0000EEEE);
        access(1'b1, 32'h4, 2'd3, 1'b0, 32'h77777777);
        access(1'b0, 32'h4, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'h556611DD, "R2", rdata, 32'h556611DD);

        // Aliasing of high address bits.
        access(1'b1, 32'h40, 2'd2, 1'b0, 32'hCAFEF00D);
        access(1'b0, 32'h0, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'hCAFEF00D, "R10", rdata, 32'hCAFEF00D);
        access(1'b0, 32'hFFFFFFF0, 2'd2, 1'b0, 32'h0);
        check(rdata === 32'hCAFEF00D, "R10", rdata, 32'hCAFEF00D);

        // Byte and halfword store sweeps, read back as words.
        for (int a = 0; a < NBYTES; a++)
            access(1'b1, 32'(a + 32'h100), 2'd0, 1'b0, 32'(a * 37 + 5));
        for (int a = 0; a < NBYTES; a += 4)
            access(1'b0, 32'(a), 2'd2, 1'b0, 32'h0);
        for (int a = 0; a < NBYTES; a++)
            access(1'b1, 32'(a), 2'd1, 1'b0, 32'(a * 4099 + 3));
        for (int a = 0; a < NBYTES; a++)
            for (int u = 0; u < 2; u++)
                access(1'b0, 32'(a), 2'd0, u[0], 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule